// File: doc/BRIEF.md
# Memory Mode Configuration Register Unit

This unit is the configuration front end on the device side of a low-power double-data-rate memory model. On every rising clock edge it samples the command pins (chip select, row strobe, column strobe, write enable), a two-bit register-select field and a 13-bit address. A programming command is recognised when all four command pins are low and clock enable has been high on both the previous and the current edge. The register-select field then steers the address word into one of two registers. The main register holds burst length, burst ordering and read latency. The auxiliary register holds the self-refresh coverage and the output drive strength.

Every programming word is checked before it is stored. A reserved code, a nonzero reserved bit, an unused select value, banks that are not all idle, or a command that arrives inside the settling gap after a write all produce a one-cycle error pulse, and the stored state is left as it was. An accepted write produces a one-cycle done pulse and starts a busy gap, so the next command is honoured no sooner than two edges later. An accepted main write also returns the auxiliary register to its defaults. Every pin is a plain level or pulse. There is no streaming interface and no back-pressure: the unit always samples its inputs.

Top module: `mode_cfg_unit`

## Requirements
- R1: A programming command is taken only when cs_n_i, ras_n_i, cas_n_i and we_n_i are all low and cke_i was high on both the previous and the current rising edge. With chip select high, with clock enable low on either edge, or for any other command pattern, nothing is stored and no error or done pulse is raised.
- R2: ba_i = 2'b00 targets the main register and ba_i = 2'b10 targets the auxiliary register. A programming command with ba_i = 2'b01 or 2'b11 is rejected.
- R3: Main address bits [2:0] give the burst length. 001, 010, 011 and 100 give burst_len_o = 2, 4, 8 and 16. Any other code is reserved and rejected.
- R4: Main address bit 3 gives burst_interleave_o (0 sequential, 1 interleaved). Bits [6:4] give the read latency: 010 gives cas_lat_o = 2, 011 gives 3, and every other code is reserved and rejected.
- R5: Auxiliary bits [2:0] give refresh_area_o: 000 full = 0, 001 half = 1, 010 quarter = 2; other codes are rejected. Bits [6:5] give drive_str_o: 00 full, 01 half, 10 quarter, 11 eighth, reported as the same 2-bit code.
- R6: An accepted main-register write sets the auxiliary outputs to their defaults on the same edge: drive_str_o = 01 (half) and refresh_area_o = 0 (full).
- R7: After an accepted write, busy_o is high for the following cycle. Any command other than NOP on the next edge, including a legal programming command, is rejected. A command two edges after the write is honoured.
- R8: A programming command sampled while banks_idle_i is low is rejected.
- R9: Reserved bits must be zero: main bits [12:7], and auxiliary bits [12:7] and [4:3]. A rejected command raises prog_error_o for exactly the cycle after the edge and leaves every register output unchanged.
- R10: mode_valid_o is low after reset and rises only with the first accepted main write. An auxiliary write alone does not raise it, and once high it stays high.
- R11: After reset burst_len_o = 0, cas_lat_o = 0, burst_interleave_o = 0, refresh_area_o = 0, drive_str_o = 01, and busy_o, prog_done_o and prog_error_o are low.
- R12: An accepted write raises prog_done_o for exactly the cycle after the edge. prog_done_o and prog_error_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Register select (00 main, 10 auxiliary) |
| addr_i | input | 13 | Programming word |
| banks_idle_i | input | 1 | High when every bank is idle |
| burst_len_o | output | 5 | Burst length in beats (0 until programmed) |
| burst_interleave_o | output | 1 | 1 for interleaved burst order |
| cas_lat_o | output | 2 | Read latency in cycles (0 until programmed) |
| refresh_area_o | output | 2 | Self-refresh coverage: 0 full, 1 half, 2 quarter |
| drive_str_o | output | 2 | Drive strength code: 0 full, 1 half, 2 quarter, 3 eighth |
| mode_valid_o | output | 1 | Main register has been programmed |
| busy_o | output | 1 | Settling gap after an accepted write |
| prog_done_o | output | 1 | One-cycle pulse for an accepted write |
| prog_error_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench sends a legal write straight after another one. A unit that counts the gap wrongly either accepts it, so the outputs change with no error, or blocks the write two edges later. It also writes the auxiliary register and then the main register, and checks that the drive strength falls back to half. A unit that kept the auxiliary state would still show the old code. Every reserved burst, latency and coverage code is sent, along with stray reserved bits, odd select values and banks that are not idle, to show that none of them changes an output and that each raises exactly one error pulse. Clock enable is raised on the same edge as a write, so that a unit which looks only at the current clock-enable level accepts that write.

// File: rtl/mode_cfg_pkg.sv
`timescale 1ns/1ps
package mode_cfg_pkg;

  typedef enum logic [1:0] {
    SEL_MAIN  = 2'b00,
    SEL_BAD01 = 2'b01,
    SEL_AUX   = 2'b10,
    SEL_BAD11 = 2'b11
  } reg_sel_e;

  // stored form of the main register (latency keeps only its low two bits)
  typedef struct packed {
    logic [2:0] bl_code;
    logic       interleave;
    logic [1:0] cl;
  } main_fields_t;

  // stored form of the auxiliary register
  typedef struct packed {
    logic [1:0] area;
    logic [1:0] drv;
  } aux_fields_t;

  localparam aux_fields_t AUX_DEFAULT = '{area: 2'd0, drv: 2'b01};

  // field positions inside the programming word
  localparam int BL_LSB   = 0;
  localparam int BT_BIT   = 3;
  localparam int CL_LSB   = 4;
  localparam int AREA_LSB = 0;
  localparam int GAP_LSB  = 3;
  localparam int DRV_LSB  = 5;
  localparam int RSV_LSB  = 7;

endpackage

// File: rtl/cfg_cmd_decode.sv
`timescale 1ns/1ps
module cfg_cmd_decode
  import mode_cfg_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              cke_prev,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              busy,
  output logic              wr_main_ok,
  output logic              wr_aux_ok,
  output logic              reject,
  output main_fields_t      main_f,
  output aux_fields_t       aux_f
);

  logic       live, is_cmd, is_wr;
  logic [2:0] bl_code, cl_code, area_code;
  logic       rsv_hi_zero, main_code_ok, aux_code_ok, gate_ok;
  reg_sel_e   sel;

  always_comb begin
    sel       = reg_sel_e'(ba);
    live      = cke_prev & cke & ~cs_n;
    is_cmd    = live & ~(ras_n & cas_n & we_n);
    is_wr     = live & ~ras_n & ~cas_n & ~we_n;
    bl_code   = addr[BL_LSB +: 3];
    cl_code   = addr[CL_LSB +: 3];
    area_code = addr[AREA_LSB +: 3];
    rsv_hi_zero  = (addr[ADDR_W-1:RSV_LSB] == '0);
    main_code_ok = rsv_hi_zero && (bl_code >= 3'd1) && (bl_code <= 3'd4) &&
                   ((cl_code == 3'd2) || (cl_code == 3'd3));
    aux_code_ok  = rsv_hi_zero && (area_code <= 3'd2) &&
                   (addr[GAP_LSB +: 2] == 2'b00);
    gate_ok      = is_wr & ~busy & banks_idle;
    wr_main_ok   = gate_ok & (sel == SEL_MAIN) & main_code_ok;
    wr_aux_ok    = gate_ok & (sel == SEL_AUX)  & aux_code_ok;
    reject       = (is_cmd & busy) | (is_wr & ~(wr_main_ok | wr_aux_ok));
    main_f.bl_code    = bl_code;
    main_f.interleave = addr[BT_BIT];
    main_f.cl         = cl_code[1:0];
    aux_f.area        = area_code[1:0];
    aux_f.drv         = addr[DRV_LSB +: 2];
  end

endmodule

// File: rtl/cfg_gap_timer.sv
`timescale 1ns/1ps
module cfg_gap_timer #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  generate
    if (GAP_CYCLES > 1) begin : g_gap_chk
      // R7: an accepted write always opens a busy window
      assert_busy_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end
  endgenerate

endmodule

// File: rtl/cfg_reg_store.sv
`timescale 1ns/1ps
module cfg_reg_store
  import mode_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_main,
  input  logic         wr_aux,
  input  main_fields_t main_in,
  input  aux_fields_t  aux_in,
  output logic [4:0]   burst_len,
  output logic         interleave,
  output logic [1:0]   cas_lat,
  output logic [1:0]   area,
  output logic [1:0]   drv,
  output logic         valid
);

  main_fields_t main_q;
  aux_fields_t  aux_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      aux_q  <= AUX_DEFAULT;
      valid  <= 1'b0;
    end else if (wr_main) begin
      main_q <= main_in;
      aux_q  <= AUX_DEFAULT;
      valid  <= 1'b1;
    end else if (wr_aux) begin
      aux_q  <= aux_in;
    end
  end

  always_comb begin
    burst_len  = valid ? (5'd1 << main_q.bl_code) : 5'd0;
    interleave = valid & main_q.interleave;
    cas_lat    = valid ? main_q.cl : 2'd0;
    area       = aux_q.area;
    drv        = aux_q.drv;
  end

  // R6: a main write brings the auxiliary state back to its defaults
  assert_aux_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_main |=> (area == 2'd0 && drv == 2'b01));
  // R10: once programmed, the main register stays valid
  assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(valid));
  // R3: a programmed burst length is a single power of two between 2 and 16
  assert_bl_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($onehot(burst_len) && burst_len >= 5'd2));
  // R4: a programmed latency is 2 or 3
  assert_cl_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cas_lat == 2'd2 || cas_lat == 2'd3));

endmodule

// File: rtl/mode_cfg_unit.sv
`timescale 1ns/1ps
module mode_cfg_unit
  import mode_cfg_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_i,
  input  logic              cs_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic [4:0]        burst_len_o,
  output logic              burst_interleave_o,
  output logic [1:0]        cas_lat_o,
  output logic [1:0]        refresh_area_o,
  output logic [1:0]        drive_str_o,
  output logic              mode_valid_o,
  output logic              busy_o,
  output logic              prog_done_o,
  output logic              prog_error_o
);

  logic         cke_prev;
  logic         wr_main_ok, wr_aux_ok, reject, busy;
  main_fields_t main_f;
  aux_fields_t  aux_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev     <= 1'b0;
      prog_done_o  <= 1'b0;
      prog_error_o <= 1'b0;
    end else begin
      cke_prev     <= cke_i;
      prog_done_o  <= wr_main_ok | wr_aux_ok;
      prog_error_o <= reject;
    end
  end

  cfg_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .cke_prev   (cke_prev),
    .cke        (cke_i),
    .cs_n       (cs_n_i),
    .ras_n      (ras_n_i),
    .cas_n      (cas_n_i),
    .we_n       (we_n_i),
    .ba         (ba_i),
    .addr       (addr_i),
    .banks_idle (banks_idle_i),
    .busy       (busy),
    .wr_main_ok (wr_main_ok),
    .wr_aux_ok  (wr_aux_ok),
    .reject     (reject),
    .main_f     (main_f),
    .aux_f      (aux_f)
  );

  cfg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_main_ok | wr_aux_ok),
    .busy  (busy)
  );

  cfg_reg_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_main    (wr_main_ok),
    .wr_aux     (wr_aux_ok),
    .main_in    (main_f),
    .aux_in     (aux_f),
    .burst_len  (burst_len_o),
    .interleave (burst_interleave_o),
    .cas_lat    (cas_lat_o),
    .area       (refresh_area_o),
    .drv        (drive_str_o),
    .valid      (mode_valid_o)
  );

  assign busy_o = busy;

  // R12: done and error never coincide
  assert_done_err_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_done_o && prog_error_o));
  // R9: a rejected command leaves every register output as it was
  assert_reject_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_error_o |-> $stable({burst_len_o, burst_interleave_o, cas_lat_o,
                              refresh_area_o, drive_str_o, mode_valid_o}));
  // R1: an accepted write was sampled with chip select low and clock enable high
  assert_write_needs_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_main_ok || wr_aux_ok) |-> (cke_i && cke_prev && !cs_n_i));
  // R8: nothing is stored while any bank is open
  assert_idle_required_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !banks_idle_i |=> !prog_done_o);

endmodule

// File: tb/test_mode_cfg_unit.sv
`timescale 1ns/1ps
module test_mode_cfg_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
  logic [1:0]  ba_i = 2'b00;
  logic [12:0] addr_i = '0;
  logic        banks_idle_i = 1'b1;
  logic [4:0]  burst_len_o;
  logic        burst_interleave_o, mode_valid_o, busy_o, prog_done_o, prog_error_o;
  logic [1:0]  cas_lat_o, refresh_area_o, drive_str_o;

  always #2 clk = ~clk;

  mode_cfg_unit i_mode_cfg_unit (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i),
    .cas_n_i(cas_n_i), .we_n_i(we_n_i), .ba_i(ba_i), .addr_i(addr_i),
    .banks_idle_i(banks_idle_i), .burst_len_o(burst_len_o),
    .burst_interleave_o(burst_interleave_o), .cas_lat_o(cas_lat_o),
    .refresh_area_o(refresh_area_o), .drive_str_o(drive_str_o),
    .mode_valid_o(mode_valid_o), .busy_o(busy_o), .prog_done_o(prog_done_o),
    .prog_error_o(prog_error_o)
  );

  typedef struct {
    int         due;
    logic [4:0] bl;
    logic       bt;
    logic [1:0] cl, area, drv;
    logic       valid, busy, done, err;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   compared = 0, mismatched = 0;
  bit   finished = 0;

  // reference state, updated from the requirements
  logic [4:0] m_bl = 0;
  logic       m_bt = 0, m_valid = 0, m_busy = 0, m_last_cke = 0;
  logic [1:0] m_cl = 0, m_area = 0, m_drv = 2'b01;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (burst_len_o !== e.bl || burst_interleave_o !== e.bt || cas_lat_o !== e.cl ||
          refresh_area_o !== e.area || drive_str_o !== e.drv || mode_valid_o !== e.valid ||
          busy_o !== e.busy || prog_done_o !== e.done || prog_error_o !== e.err) begin
        mismatched++;
        $display("FAIL %s: got bl=%0d bt=%0d cl=%0d area=%0d drv=%0d valid=%0d busy=%0d done=%0d err=%0d exp bl=%0d bt=%0d cl=%0d area=%0d drv=%0d valid=%0d busy=%0d done=%0d err=%0d",
          e.tag, burst_len_o, burst_interleave_o, cas_lat_o, refresh_area_o, drive_str_o,
          mode_valid_o, busy_o, prog_done_o, prog_error_o,
          e.bl, e.bt, e.cl, e.area, e.drv, e.valid, e.busy, e.done, e.err);
      end
    end
  end

  function automatic logic [12:0] main_word(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    return {6'b0, cl, bt, bl};
  endfunction

  function automatic logic [12:0] aux_word(input logic [1:0] drv, input logic [2:0] area);
    return {6'b0, drv, 2'b00, area};
  endfunction

  // driver: applies one cycle of inputs and queues the expected result
  task automatic issue(input logic cke, input logic cs, input logic ras, input logic cas,
                       input logic we, input logic [1:0] ba, input logic [12:0] a,
                       input logic idle, input string tag);
    logic live, iscmd, iswr, ok, err;
    exp_t e;
    cke_i = cke; cs_n_i = cs; ras_n_i = ras; cas_n_i = cas; we_n_i = we;
    ba_i = ba; addr_i = a; banks_idle_i = idle;
    live  = m_last_cke && cke && !cs;
    iscmd = live && !(ras && cas && we);
    iswr  = live && !ras && !cas && !we;
    ok = 1'b0;
    if (iswr && !m_busy && idle) begin
      if (ba == 2'b00 && a[2:0] >= 3'd1 && a[2:0] <= 3'd4 &&
          (a[6:4] == 3'd2 || a[6:4] == 3'd3) && a[12:7] == 6'd0) begin
        ok = 1'b1;
        m_bl = 5'd1 << a[2:0]; m_bt = a[3]; m_cl = a[5:4];
        m_area = 2'd0; m_drv = 2'b01; m_valid = 1'b1;
      end else if (ba == 2'b10 && a[2:0] <= 3'd2 && a[4:3] == 2'b00 && a[12:7] == 6'd0) begin
        ok = 1'b1;
        m_area = a[1:0]; m_drv = a[6:5];
      end
    end
    err = (iscmd && m_busy) || (iswr && !ok);
    e.due = cyc + 1; e.bl = m_bl; e.bt = m_bt; e.cl = m_cl; e.area = m_area;
    e.drv = m_drv; e.valid = m_valid; e.busy = ok; e.done = ok; e.err = err; e.tag = tag;
    q.push_back(e);
    m_busy = ok;
    m_last_cke = cke;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop(input string tag);
    issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 13'd0, 1'b1, tag);
  endtask

  task automatic wr(input logic [1:0] ba, input logic [12:0] a, input logic idle, input string tag);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ba, a, idle, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nop("R11 reset state");
    wr(2'b10, aux_word(2'b10, 3'b001), 1'b1, "R10 aux write alone keeps valid low");
    nop("R7 nop inside busy window is not an error");
    wr(2'b00, main_word(3'b010, 1'b0, 3'b011), 1'b1, "R6 main write restores aux defaults, bl4 cl3");
    wr(2'b00, main_word(3'b011, 1'b1, 3'b010), 1'b1, "R7 legal write one edge after write rejected");
    wr(2'b00, main_word(3'b011, 1'b1, 3'b010), 1'b1, "R3 R4 bl8 interleaved cl2 two edges later");
    nop("R12 done pulse lasts one cycle");
    wr(2'b00, main_word(3'b100, 1'b0, 3'b011), 1'b1, "R3 bl16");
    nop("R7 gap");
    wr(2'b00, main_word(3'b001, 1'b0, 3'b011), 1'b1, "R3 bl2");
    nop("R7 gap");
    wr(2'b00, main_word(3'b101, 1'b0, 3'b011), 1'b1, "R3 reserved burst code rejected");
    wr(2'b00, main_word(3'b000, 1'b0, 3'b011), 1'b1, "R3 burst code 000 rejected");
    wr(2'b00, main_word(3'b010, 1'b0, 3'b100), 1'b1, "R4 reserved latency rejected");
    wr(2'b00, main_word(3'b010, 1'b0, 3'b001), 1'b1, "R4 latency code 001 rejected");
    wr(2'b00, main_word(3'b010, 1'b0, 3'b011) | 13'h0200, 1'b1, "R9 main reserved bit rejected");
    wr(2'b10, aux_word(2'b00, 3'b011), 1'b1, "R5 reserved area rejected");
    wr(2'b10, aux_word(2'b00, 3'b000) | 13'h0008, 1'b1, "R9 aux reserved bit rejected");
    wr(2'b01, main_word(3'b010, 1'b0, 3'b011), 1'b1, "R2 select 01 rejected");
    wr(2'b11, aux_word(2'b11, 3'b000), 1'b1, "R2 select 11 rejected");
    wr(2'b00, main_word(3'b010, 1'b0, 3'b011), 1'b0, "R8 banks not idle rejected");
    wr(2'b10, aux_word(2'b11, 3'b010), 1'b1, "R5 eighth drive quarter area");
    nop("R7 gap");
    wr(2'b10, aux_word(2'b00, 3'b000), 1'b1, "R5 full drive full area");
    nop("R7 gap");
    issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 13'd0, 1'b1, "R1 clock enable low");
    wr(2'b00, main_word(3'b100, 1'b1, 3'b010), 1'b1, "R1 write as clock enable rises ignored");
    wr(2'b00, main_word(3'b100, 1'b1, 3'b010), 1'b1, "R1 write with clock enable steady taken");
    issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'd0, 1'b1, "R7 other command inside gap rejected");
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, main_word(3'b001, 1'b0, 3'b011), 1'b1, "R1 chip select high ignored");
    issue(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'd0, 1'b1, "R1 non-write command outside gap no effect");
    wr(2'b10, aux_word(2'b10, 3'b010), 1'b1, "R5 quarter drive quarter area");
    nop("R7 gap");
    wr(2'b00, main_word(3'b011, 1'b0, 3'b010), 1'b1, "R6 main write resets aux again");
    nop("R10 valid stays high");
    nop("R12 drain");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule